// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 24-bit virtual address into a physical address by walking two tables held in word-addressed memory. The top four address bits select a segment descriptor. That descriptor sits in a segment table whose base comes from a base-register input. A valid descriptor supplies the base of a 256-entry page table, and the middle eight bits select the page entry inside it. A valid page entry supplies a 12-bit physical frame number. The low twelve bits of the virtual address pass through unchanged as the byte offset.

While it walks, the block keeps the status bits of the page entry up to date. Every successful translation marks the entry as referenced. A translation for a store also marks it as modified. The updated word is written back to memory only when one of those bits actually changes. An invalid descriptor or an invalid page entry ends the walk with a fault and a cause code. The block talks to memory through a request/ready port with a separate read-data strobe, so any number of wait cycles is allowed. It handles one walk at a time.

Top module: `seg_page_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `resp_valid` and `mem_req` are 0. `req_ready` is 1 only while no walk is in progress, and a request is taken when `req_valid` and `req_ready` are both 1.
- R2: The first memory access of a walk is a read (`mem_we`=0) of word address `seg_base + vaddr[23:20]`, taken modulo 2^16.
- R3: If bit 31 of the descriptor word is 0, the walk ends with `resp_fault`=1 and `resp_cause`=0, and no further memory access takes place.
- R4: If the descriptor is valid, the second access is a read of word address `desc[15:0] + vaddr[19:12]`, taken modulo 2^16.
- R5: If bit 31 of the page entry is 0, the walk ends with `resp_fault`=1 and `resp_cause`=1, and there is no write.
- R6: For a valid page entry, `resp_fault`=0 and `resp_paddr` = {entry[11:0], vaddr[11:0]}.
- R7: Write-back goes to the page entry's own address with bit 30 (referenced) set. Bit 29 (modified) is also set when `req_write` was 1. All other bits are copied from the entry as read.
- R8: The write-back is issued only if it changes the entry. An entry that already has the bits it needs produces no write.
- R9: While `mem_req` is 1 and `mem_ready` is 0, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values. Read data may arrive in the cycle the read is accepted or any number of cycles later.
- R10: Each accepted request yields exactly one single-cycle `resp_valid`. It comes after the walk's last memory access has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 24 | Virtual address to translate |
| req_write | input | 1 | Access being translated is a store |
| seg_base | input | 16 | Word address of the segment table |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 1 | Fault cause: 0 segment, 1 page |
| resp_paddr | output | 24 | Physical address when no fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Acceptance of a read and the return of its data can fall in the same cycle. When they do, the walker must take the data at once, without marking the read as outstanding, and go straight on to the next step. The bench runs the full set of walks in a zero-latency memory mode, where `mem_rvalid` rises in the very cycle `mem_ready` accepts the read. It then repeats the same walks with ready stalls and multi-cycle latency. In every mode, each accepted access is compared on the clock against the access sequence the bench's own table model predicts: address, direction and write data. Each result pulse is compared against the predicted fault, cause and physical address. A dropped or doubled read therefore shows up as a miscompare or a hang.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_PTE,
    ST_WB,
    ST_DONE
  } walk_state_e;

  localparam logic CAUSE_SEG  = 1'b0;
  localparam logic CAUSE_PAGE = 1'b1;
endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic              pick_pte,
  input  logic [ADDR_W-1:0] tab_base,
  input  logic [SEG_W-1:0]  seg_idx,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic [PAGE_W-1:0] page_idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] page_ext;

  assign seg_ext  = {{(ADDR_W-SEG_W){1'b0}}, seg_idx};
  assign page_ext = {{(ADDR_W-PAGE_W){1'b0}}, page_idx};

  always_comb begin
    if (pick_pte) addr = pt_base + page_ext;
    else          addr = tab_base + seg_ext;
  end
endmodule

// File: rtl/pte_merge.sv
module pte_merge #(
  parameter int DATA_W    = 32,
  parameter int REF_BIT   = 30,
  parameter int DIRTY_BIT = 29
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic              is_write,
  output logic [DATA_W-1:0] new_word,
  output logic              changed
);
  always_comb begin
    new_word          = old_word;
    new_word[REF_BIT] = 1'b1;
    if (is_write) new_word[DIRTY_BIT] = 1'b1;
  end

  assign changed = (new_word != old_word);
endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SEG_W     = 4,
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 12,
  parameter int PPN_W     = 12,
  parameter int VALID_BIT = 31,
  parameter int REF_BIT   = 30,
  parameter int DIRTY_BIT = 29
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             seg_base,
  output logic                          resp_valid,
  output logic                          resp_fault,
  output logic                          resp_cause,
  output logic [PPN_W+OFF_W-1:0]        resp_paddr,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic                          mem_ready,
  input  logic                          mem_rvalid,
  input  logic [DATA_W-1:0]             mem_rdata
);
  localparam int VA_W     = SEG_W + PAGE_W + OFF_W;
  localparam int PA_W     = PPN_W + OFF_W;
  localparam int PAGE_LSB = OFF_W;
  localparam int SEG_LSB  = OFF_W + PAGE_W;

  walk_state_e       state;
  logic              issued;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ptb_q;
  logic [DATA_W-1:0] wb_q;

  logic              in_read;
  logic              mem_accept;
  logic              rd_done;
  logic [DATA_W-1:0] merged;
  logic              needs_wb;

  // Memory-side controls come straight from state registers.
  assign in_read    = (state == ST_SEG) || (state == ST_PTE);
  assign mem_req    = (in_read && !issued) || (state == ST_WB);
  assign mem_we     = (state == ST_WB);
  assign mem_wdata  = wb_q;
  assign mem_accept = mem_req && mem_ready;
  // Data may arrive with the acceptance itself or any time later.
  assign rd_done    = in_read && mem_rvalid && (issued || mem_accept);

  assign req_ready  = (state == ST_IDLE);
  assign resp_valid = (state == ST_DONE);

  walk_addr_gen #(
    .ADDR_W (ADDR_W),
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W)
  ) u_addr (
    .pick_pte (state != ST_SEG),
    .tab_base (base_q),
    .seg_idx  (va_q[SEG_LSB +: SEG_W]),
    .pt_base  (ptb_q),
    .page_idx (va_q[PAGE_LSB +: PAGE_W]),
    .addr     (mem_addr)
  );

  pte_merge #(
    .DATA_W    (DATA_W),
    .REF_BIT   (REF_BIT),
    .DIRTY_BIT (DIRTY_BIT)
  ) u_merge (
    .old_word (mem_rdata),
    .is_write (wr_q),
    .new_word (merged),
    .changed  (needs_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      issued     <= 1'b0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      base_q     <= '0;
      ptb_q      <= '0;
      wb_q       <= '0;
      resp_fault <= 1'b0;
      resp_cause <= 1'b0;
      resp_paddr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            base_q <= seg_base;
            issued <= 1'b0;
            state  <= ST_SEG;
          end
        end
        ST_SEG: begin
          if (rd_done) begin
            issued <= 1'b0;
            if (mem_rdata[VALID_BIT]) begin
              ptb_q <= mem_rdata[ADDR_W-1:0];
              state <= ST_PTE;
            end else begin
              resp_fault <= 1'b1;
              resp_cause <= CAUSE_SEG;
              resp_paddr <= '0;
              state      <= ST_DONE;
            end
          end else if (mem_accept) begin
            issued <= 1'b1;
          end
        end
        ST_PTE: begin
          if (rd_done) begin
            issued <= 1'b0;
            if (!mem_rdata[VALID_BIT]) begin
              resp_fault <= 1'b1;
              resp_cause <= CAUSE_PAGE;
              resp_paddr <= '0;
              state      <= ST_DONE;
            end else begin
              resp_fault <= 1'b0;
              resp_cause <= 1'b0;
              resp_paddr <= {mem_rdata[PPN_W-1:0], va_q[OFF_W-1:0]};
              wb_q       <= merged;
              state      <= needs_wb ? ST_WB : ST_DONE;
            end
          end else if (mem_accept) begin
            issued <= 1'b1;
          end
        end
        ST_WB: begin
          if (mem_ready) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  // R7
  wb_ref_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[REF_BIT]);

  // R3
  seg_fault_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault && (resp_cause == CAUSE_SEG)) |-> ($past(state) == ST_SEG));

  // R5
  page_fault_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault && (resp_cause == CAUSE_PAGE)) |-> ($past(state) == ST_PTE));
endmodule

// File: tb/test_seg_page_walker.sv
module test_seg_page_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [15:0] seg_base = 16'h0100;
  logic        resp_valid, resp_fault, resp_cause;
  logic [23:0] resp_paddr;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  seg_page_walker i_seg_page_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .seg_base(seg_base),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
    .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int vectors = 0;
  int fails = 0;

  logic [31:0] mem_img [int];
  logic [15:0] q_addr [$];
  logic        q_we   [$];
  logic [31:0] q_wd   [$];
  string       q_tag  [$];

  int stall_cfg = 0, lat_cfg = 0;
  int wait_ctr = 0, pend_cnt = 0;
  logic [15:0] pend_addr = '0;
  bit   prev_acc = 0, prev_we = 0;
  logic [15:0] prev_addr = '0;
  logic [31:0] prev_wd = '0;
  bit   busy = 0, pending = 0;
  bit   exp_fault = 0, exp_cause = 0;
  logic [23:0] exp_paddr = '0;
  int   resp_count = 0;

  function automatic logic [31:0] rd(input logic [15:0] a);
    if (mem_img.exists(int'(a))) return mem_img[int'(a)];
    return 32'h0;
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Memory model and per-clock comparison, all away from the rising edge.
  always @(negedge clk) begin
    if (rst) begin
      wait_ctr = stall_cfg; pend_cnt = 0; prev_acc = 0;
      mem_ready = 0; mem_rvalid = 0;
    end else begin
      if (prev_acc) begin
        if (prev_we) mem_img[int'(prev_addr)] = prev_wd;
        else if (lat_cfg > 0) begin pend_cnt = lat_cfg; pend_addr = prev_addr; end
        wait_ctr = stall_cfg;
      end else begin
        if (wait_ctr > 0) wait_ctr--;
        if (pend_cnt > 0) pend_cnt--;
      end
      mem_ready  = (wait_ctr == 0) && (pend_cnt == 0);
      if (lat_cfg == 0) begin
        mem_rvalid = mem_req && mem_ready && !mem_we;
        mem_rdata  = rd(mem_addr);
      end else begin
        mem_rvalid = (pend_cnt == 1);
        mem_rdata  = rd(pend_addr);
      end
      prev_acc  = mem_req && mem_ready;
      prev_we   = mem_we;
      prev_addr = mem_addr;
      prev_wd   = mem_wdata;

      // R1 ready follows the bench's own busy tracking every cycle
      chk("R1", "req_ready", {31'b0, req_ready}, {31'b0, !busy});

      if (prev_acc) begin
        if (q_addr.size() == 0) begin
          chk("R8", "unexpected access addr", {16'b0, mem_addr}, 32'hFFFF_FFFF);
        end else begin
          string t;
          logic [31:0] ew;
          t = q_tag.pop_front();
          chk(t, "access addr", {16'b0, mem_addr}, {16'b0, q_addr.pop_front()});
          chk(t, "access dir", {31'b0, mem_we}, {31'b0, q_we.pop_front()});
          ew = q_wd.pop_front();
          if (mem_we) chk(t, "write data", mem_wdata, ew);
        end
      end

      if (resp_valid) begin
        string t;
        t = exp_fault ? (exp_cause ? "R5" : "R3") : "R6";
        chk("R10", "response expected", {31'b0, pending}, 32'h1);
        chk(t, "fault", {31'b0, resp_fault}, {31'b0, exp_fault});
        if (exp_fault) chk(t, "cause", {31'b0, resp_cause}, {31'b0, exp_cause});
        else           chk(t, "paddr", {8'b0, resp_paddr}, {8'b0, exp_paddr});
        chk("R10", "accesses left", q_addr.size(), 0);
        pending = 0;
        busy = 0;
        resp_count++;
      end

      if (req_valid && req_ready) busy = 1;
    end
  end

  task automatic walk(input logic [3:0] seg, input logic [7:0] pg,
                      input logic [11:0] off, input bit wr);
    logic [15:0] sa, pa;
    logic [31:0] sw, pw, nw;
    int target;
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    sa = seg_base + {12'b0, seg};
    q_addr.push_back(sa); q_we.push_back(0); q_wd.push_back(0); q_tag.push_back("R2");
    sw = rd(sa);
    if (!sw[31]) begin
      exp_fault = 1; exp_cause = 0;
    end else begin
      pa = sw[15:0] + {8'b0, pg};
      q_addr.push_back(pa); q_we.push_back(0); q_wd.push_back(0); q_tag.push_back("R4");
      pw = rd(pa);
      if (!pw[31]) begin
        exp_fault = 1; exp_cause = 1;
      end else begin
        exp_fault = 0;
        exp_paddr = {pw[11:0], off};
        nw = pw | 32'h4000_0000 | (wr ? 32'h2000_0000 : 32'h0);
        if (nw != pw) begin
          q_addr.push_back(pa); q_we.push_back(1); q_wd.push_back(nw); q_tag.push_back("R7");
        end
      end
    end
    pending = 1;
    target = resp_count + 1;
    req_vaddr = {seg, pg, off};
    req_write = wr;
    req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    while (resp_count < target) begin @(posedge clk); #1; end
  endtask

  task automatic load_tables();
    mem_img.delete();
    mem_img[32'h0100] = 32'h8000_1000;  // segment 0
    mem_img[32'h0101] = 32'h0000_3000;  // segment 1 invalid
    mem_img[32'h010F] = 32'h8000_2000;  // segment 15 (last index)
    mem_img[32'h1000] = 32'h8000_0ABC;  // clean valid page
    mem_img[32'h10FF] = 32'hE000_0123;  // already referenced and modified
    mem_img[32'h1005] = 32'h6000_0777;  // invalid, status bits set
    mem_img[32'h1007] = 32'hC000_0456;  // referenced only
    mem_img[32'h2003] = 32'h8000_0FFF;
  endtask

  task automatic run_set();
    load_tables();
    walk(4'h0, 8'h00, 12'h123, 0);  // R6 R7 referenced set
    walk(4'h0, 8'h00, 12'h456, 0);  // R8 nothing to change
    walk(4'h0, 8'h00, 12'hFFF, 1);  // R7 modified added
    walk(4'h0, 8'hFF, 12'h000, 1);  // R8 already full status
    walk(4'h1, 8'h00, 12'h001, 0);  // R3 segment invalid
    walk(4'h2, 8'h10, 12'h002, 1);  // R3 empty descriptor
    walk(4'h0, 8'h05, 12'h003, 1);  // R5 page invalid, no write
    walk(4'h0, 8'h07, 12'h800, 0);  // R8 read on referenced entry
    walk(4'h0, 8'h07, 12'h801, 1);  // R7 store on referenced entry
    walk(4'hF, 8'h03, 12'hABC, 1);  // R2 R4 last segment index
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "reset req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "reset resp_valid", {31'b0, resp_valid}, 32'h0);
    chk("R1", "reset mem_req", {31'b0, mem_req}, 32'h0);

    stall_cfg = 0; lat_cfg = 0; run_set();  // R9 data with acceptance
    stall_cfg = 2; lat_cfg = 1; run_set();  // R9 stalled ready
    stall_cfg = 1; lat_cfg = 4; run_set();  // R9 long latency
    stall_cfg = 3; lat_cfg = 0; run_set();

    repeat (5) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual no response expected response");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule